// File: doc/BRIEF.md
# Reservation-tracking shared memory port for load-linked / store-conditional

This block is a shared word memory that several cores reach through one arbitrated port. Each core can issue four kinds of access: a plain load, a plain store, a load-linked and a store-conditional. A load-linked returns the addressed word and records an address reservation for the issuing core. A later store-conditional from that core writes only while that reservation is still intact, and it reports the outcome as a 1 or a 0 in the response word.

Each core owns a single reservation register. Any write that reaches the reserved word from anywhere destroys the reservation. This includes another core's store, another core's successful conditional store, and the core's own plain store. A conditional store therefore fails whenever some other agent got between its two halves. Software builds a spin lock on top of this. It repeats the load-linked while the lock word reads nonzero, then attempts a conditional store of 1, and restarts the whole sequence when that returns 0.

Requests that arrive together are serialized by a fixed-priority arbiter, and the lowest-numbered core goes first. Each granted access takes effect in its grant cycle, so the next grant already sees the reservations that the previous write cancelled.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no response is pending (rsp_valid is 0, grant is 0 with no requests), and every reservation is invalid, so a store-conditional issued before any load-linked fails.
- R2: The word address of every access is req_base plus req_off, truncated to AW bits (so it wraps modulo 2^AW). A load (op code 0) returns the word stored at that address.
- R3: A store (op code 1) writes req_wdata to the addressed word and returns a response word of 0.
- R4: A load-linked (op code 2) returns the addressed word and records a reservation of that address for the issuing core.
- R5: A store-conditional (op code 3) whose core holds a valid reservation of the same address writes req_wdata and returns 1.
- R6: A store-conditional without a valid reservation, or to an address other than the reserved one, returns 0 and leaves memory unchanged.
- R7: A write to a reserved address by another core cancels that reservation. The write may be a store or a successful store-conditional, and the cancelled core's next store-conditional then fails.
- R8: A core's own plain store to its reserved address cancels its reservation.
- R9: Every store-conditional clears the issuing core's reservation whether it succeeds or fails, so a second store-conditional without a new load-linked fails.
- R10: A new load-linked replaces the core's previous reservation, so only the latest reserved address can succeed.
- R11: grant is combinational and one-hot, and it selects the lowest-numbered requesting core. The response appears one cycle later on rsp_valid (one bit per core) and rsp_data. Simultaneous requests are served in ascending core order, one per cycle.
- R12: A write to an address other than the reserved one leaves the reservation intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NCORE | Per-core request, held until granted |
| req_op | input | 2*NCORE | Per-core op code: 0 load, 1 store, 2 load-linked, 3 store-conditional |
| req_base | input | AW*NCORE | Per-core base word address |
| req_off | input | AW*NCORE | Per-core offset added to the base |
| req_wdata | input | DW*NCORE | Per-core write data |
| grant | output | NCORE | One-hot grant for the current cycle |
| rsp_valid | output | NCORE | One-hot response strobe, one cycle after grant |
| rsp_data | output | DW | Read word, 0 for a store, 1/0 result for a store-conditional |

## Verification
Single-core sequences separate the reservation rules from each other. A conditional store right after reset, a second conditional store after a successful one, and one aimed at a different address must all fail without writing. One that follows its own load-linked must succeed. A second core's store between the two halves shows cancellation by foreign writes, and a write to another word shows that unrelated traffic leaves the reservation alone. A core's own store and a double load-linked cover self-cancellation and replacement. Bursts where several cores request in the same cycle, including two cores racing for one lock word, show both the fixed grant order and the invalidation taking effect before the next grant.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } op_e;
  localparam int OP_W = 2;
endpackage

// File: rtl/llsc_arbiter.sv
`timescale 1ns/1ps
module llsc_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pri
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
    end
  endgenerate

  // R11
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R11
  gnt_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ((gnt & req) != '0));
endmodule

// File: rtl/llsc_resv.sv
`timescale 1ns/1ps
module llsc_resv #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic          clr_own,
  input  logic [AW-1:0] set_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic          valid,
  output logic [AW-1:0] addr
);
  logic          v_q, v_d;
  logic [AW-1:0] a_q;

  always_comb begin
    v_d = v_q;
    if (wr_en && (wr_addr == a_q)) v_d = 1'b0;
    if (clr_own) v_d = 1'b0;
    if (set) v_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (set) a_q <= set_addr;
  end

  assign valid = v_q;
  assign addr  = a_q;

  // R7 R8
  write_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && v_q && (wr_addr == a_q) && !set) |=> !v_q);

  // R9
  sc_clears_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_own && !set) |=> !v_q);

  // R10
  ll_replaces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> (v_q && (a_q == $past(set_addr))));
endmodule

// File: rtl/llsc_mem.sv
`timescale 1ns/1ps
module llsc_mem #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
    rdata <= store_q[raddr];
  end
endmodule

// File: rtl/llsc_monitor.sv
`timescale 1ns/1ps
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORE-1:0]      req_valid,
  input  logic [2*NCORE-1:0]    req_op,
  input  logic [AW*NCORE-1:0]   req_base,
  input  logic [AW*NCORE-1:0]   req_off,
  input  logic [DW*NCORE-1:0]   req_wdata,
  output logic [NCORE-1:0]      grant,
  output logic [NCORE-1:0]      rsp_valid,
  output logic [DW-1:0]         rsp_data
);
  logic [OP_W-1:0] g_op;
  logic [AW-1:0]   g_base, g_off, ea;
  logic [DW-1:0]   g_wdata;
  logic            gnt_any, sc_hit, we;
  logic [NCORE-1:0] res_v, res_set, res_clr;
  logic [AW-1:0]    res_a [NCORE];
  logic [DW-1:0]    mem_rdata;

  logic [NCORE-1:0] rsp_v_q;
  logic             rsp_mem_q, rsp_mem_d;
  logic             code_q, code_d;

  llsc_arbiter #(.N(NCORE)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid), .gnt(grant)
  );

  always_comb begin
    g_op    = '0;
    g_base  = '0;
    g_off   = '0;
    g_wdata = '0;
    for (int i = 0; i < NCORE; i++) begin
      if (grant[i]) begin
        g_op    = g_op    | req_op[i*OP_W +: OP_W];
        g_base  = g_base  | req_base[i*AW +: AW];
        g_off   = g_off   | req_off[i*AW +: AW];
        g_wdata = g_wdata | req_wdata[i*DW +: DW];
      end
    end
  end

  assign ea      = g_base + g_off;
  assign gnt_any = |grant;

  always_comb begin
    sc_hit = 1'b0;
    for (int i = 0; i < NCORE; i++) begin
      if (grant[i] && res_v[i] && (res_a[i] == ea)) sc_hit = 1'b1;
    end
  end

  assign we = gnt_any && ((g_op == OP_STORE) || ((g_op == OP_SC) && sc_hit));

  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_core
      assign res_set[c] = grant[c] && (g_op == OP_LL);
      assign res_clr[c] = grant[c] && (g_op == OP_SC);
      llsc_resv #(.AW(AW)) u_resv (
        .clk(clk), .rst_n(rst_n),
        .set(res_set[c]), .clr_own(res_clr[c]), .set_addr(ea),
        .wr_en(we), .wr_addr(ea),
        .valid(res_v[c]), .addr(res_a[c])
      );
    end
  endgenerate

  llsc_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(we), .waddr(ea), .wdata(g_wdata),
    .raddr(ea), .rdata(mem_rdata)
  );

  always_comb begin
    rsp_mem_d = rsp_mem_q;
    code_d    = code_q;
    if (gnt_any) begin
      rsp_mem_d = (g_op == OP_LOAD) || (g_op == OP_LL);
      code_d    = (g_op == OP_SC) && sc_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q   <= '0;
      rsp_mem_q <= 1'b0;
      code_q    <= 1'b0;
    end else begin
      rsp_v_q   <= grant;
      rsp_mem_q <= rsp_mem_d;
      code_q    <= code_d;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_mem_q ? mem_rdata : {{(DW-1){1'b0}}, code_q};

  // R11
  rsp_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> (rsp_valid == $past(grant)));

  // R6
  sc_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && (g_op == OP_SC) && !sc_hit) |=> (rsp_data == '0));

  // R3
  store_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && (g_op == OP_STORE)) |=> (rsp_data == '0));
endmodule

// File: tb/llsc_monitor_test.sv
`timescale 1ns/1ps
module llsc_monitor_test;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    rv = '0;
  logic [1:0]      rop [N];
  logic [AW-1:0]   rbase [N];
  logic [AW-1:0]   roff [N];
  logic [DW-1:0]   rwd [N];
  logic [2*N-1:0]  op_p;
  logic [AW*N-1:0] base_p, off_p;
  logic [DW*N-1:0] wd_p;
  logic [N-1:0]    grant, rsp_valid;
  logic [DW-1:0]   rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      op_p[i*2 +: 2]     = rop[i];
      base_p[i*AW +: AW] = rbase[i];
      off_p[i*AW +: AW]  = roff[i];
      wd_p[i*DW +: DW]   = rwd[i];
    end
  end

  llsc_monitor #(.NCORE(N), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_op(op_p),
    .req_base(base_p), .req_off(off_p), .req_wdata(wd_p),
    .grant(grant), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] mdl_mem [int];
  bit            mdl_rv [N];
  int            mdl_ra [N];
  logic [N-1:0]  exp_valid = '0;
  logic [DW-1:0] exp_data = '0;
  string         exp_tag = "R1";

  always @(posedge clk) begin
    if (rst_n) begin
      int w;
      int ea;
      w = -1;
      for (int i = N - 1; i >= 0; i--) if (rv[i]) w = i;
      exp_valid = '0;
      if (w >= 0) begin
        ea = (int'(rbase[w]) + int'(roff[w])) % (1 << AW);
        exp_valid = N'(1) << w;
        case (rop[w])
          2'd0: begin exp_data = mdl_mem[ea]; exp_tag = "R2"; end
          2'd1: begin
            mdl_mem[ea] = rwd[w];
            for (int i = 0; i < N; i++) if (mdl_ra[i] == ea) mdl_rv[i] = 0;
            exp_data = 0; exp_tag = "R3";
          end
          2'd2: begin
            exp_data = mdl_mem[ea]; mdl_rv[w] = 1; mdl_ra[w] = ea; exp_tag = "R4";
          end
          default: begin
            if (mdl_rv[w] && mdl_ra[w] == ea) begin
              mdl_mem[ea] = rwd[w];
              for (int i = 0; i < N; i++) if (mdl_ra[i] == ea) mdl_rv[i] = 0;
              exp_data = 1; exp_tag = "R5";
            end else begin
              exp_data = 0; exp_tag = "R6";
            end
            mdl_rv[w] = 0;
          end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(grant === lowest(rv), "R11 grant", DW'(grant), DW'(lowest(rv)));
      check(rsp_valid === exp_valid, "R11 rsp_valid", DW'(rsp_valid), DW'(exp_valid));
      if (exp_valid != '0)
        check(rsp_data === exp_data, exp_tag, rsp_data, exp_data);
    end
  end

  logic [DW-1:0] got [N];
  int            got_at [N];
  int            cyc;

  task automatic put(input int c, input logic [1:0] op, input int b, input int o,
                     input logic [DW-1:0] d);
    rop[c]   = op;
    rbase[c] = AW'(b);
    roff[c]  = AW'(o);
    rwd[c]   = d;
    rv[c]    = 1'b1;
  endtask

  task automatic burst();
    cyc = 0;
    while (rv != '0) begin
      @(posedge clk); #1;
      cyc++;
      for (int i = 0; i < N; i++)
        if (rsp_valid[i]) begin got[i] = rsp_data; got_at[i] = cyc; end
      rv = rv & ~lowest(rv);
    end
  endtask

  task automatic one(input int c, input logic [1:0] op, input int b, input int o,
                     input logic [DW-1:0] d, input logic [DW-1:0] exp, input string tag);
    put(c, op, b, o, d);
    burst();
    check(got[c] === exp, tag, got[c], exp);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      rop[i] = 0; rbase[i] = 0; roff[i] = 0; rwd[i] = 0;
      mdl_rv[i] = 0; mdl_ra[i] = -1; got[i] = 0; got_at[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    check(rsp_valid === '0, "R1 rsp_valid", DW'(rsp_valid), 0);
    check(grant === '0, "R1 grant", DW'(grant), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    one(0, 2'd1, 8, 2, 32'h0, 32'h0, "R3 store ack");
    one(0, 2'd1, 250, 26, 32'h55, 32'h0, "R3 store wrap");
    one(0, 2'd0, 0, 20, 0, 32'h55, "R2 wrapped address");
    one(1, 2'd3, 20, 0, 32'h7, 32'h0, "R1 sc after reset");
    one(0, 2'd0, 20, 0, 0, 32'h55, "R6 memory kept");
    one(1, 2'd2, 4, 6, 0, 32'h0, "R4 ll data");
    one(1, 2'd3, 10, 0, 32'h1, 32'h1, "R5 sc success");
    one(0, 2'd0, 10, 0, 0, 32'h1, "R5 sc wrote");
    one(1, 2'd3, 10, 0, 32'h2, 32'h0, "R9 second sc");
    one(0, 2'd0, 10, 0, 0, 32'h1, "R9 memory kept");
    one(2, 2'd2, 10, 0, 0, 32'h1, "R4 ll data");
    one(2, 2'd3, 20, 0, 32'h9, 32'h0, "R6 wrong address");
    one(0, 2'd0, 20, 0, 0, 32'h55, "R6 memory kept");
    one(2, 2'd2, 10, 0, 0, 32'h1, "R4 ll data");
    one(3, 2'd1, 10, 0, 32'h0, 32'h0, "R3 foreign store");
    one(2, 2'd3, 10, 0, 32'h5, 32'h0, "R7 cancelled by store");
    one(0, 2'd0, 10, 0, 0, 32'h0, "R7 memory kept");
    one(2, 2'd2, 10, 0, 0, 32'h0, "R4 ll data");
    one(3, 2'd1, 20, 0, 32'h66, 32'h0, "R3 other word");
    one(2, 2'd3, 10, 0, 32'h3, 32'h1, "R12 unrelated write");
    one(3, 2'd2, 20, 0, 0, 32'h66, "R4 ll data");
    one(3, 2'd1, 20, 0, 32'h77, 32'h0, "R3 own store");
    one(3, 2'd3, 20, 0, 32'h8, 32'h0, "R8 own store cancels");
    one(0, 2'd0, 20, 0, 0, 32'h77, "R8 memory kept");
    one(0, 2'd2, 10, 0, 0, 32'h3, "R4 ll data");
    one(0, 2'd2, 20, 0, 0, 32'h77, "R4 ll data");
    one(0, 2'd3, 10, 0, 32'h4, 32'h0, "R10 old reservation gone");
    one(0, 2'd2, 10, 0, 0, 32'h3, "R4 ll data");
    one(0, 2'd2, 20, 0, 0, 32'h77, "R4 ll data");
    one(0, 2'd3, 20, 0, 32'h99, 32'h1, "R10 new reservation");

    one(0, 2'd1, 30, 0, 32'h0, 32'h0, "R3 lock word");
    put(1, 2'd2, 30, 0, 0);
    put(2, 2'd2, 30, 0, 0);
    burst();
    check(got[1] === 0 && got[2] === 0, "R4 both ll", got[2], 0);
    check(got_at[1] < got_at[2], "R11 order", DW'(got_at[1]), DW'(got_at[2]));
    put(1, 2'd3, 30, 0, 32'h1);
    put(2, 2'd3, 30, 0, 32'h1);
    burst();
    check(got[1] === 32'h1, "R11 first racer wins", got[1], 1);
    check(got[2] === 32'h0, "R7 second racer loses", got[2], 0);

    for (int i = 0; i < N; i++) put(N - 1 - i, 2'd0, 20, 0, 0);
    burst();
    for (int i = 0; i < N; i++) begin
      check(got[i] === 32'h99, "R11 burst data", got[i], 32'h99);
      check(got_at[i] == i + 1, "R11 burst order", DW'(got_at[i]), DW'(i + 1));
    end

    @(posedge clk); #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule